// File: doc/BRIEF.md
# APB Address Violation Monitor

This block sits on the address decode path of an APB segment. Every transfer is compared against a set of peripheral address windows that are fixed by parameters. A transfer that falls inside a window gets that window's select line. A transfer that falls inside no window is a violation, and the block answers it itself. The transfer completes in its access phase with an OKAY response, because APB has no way to report an error type. A read returns zero data, and an interrupt pulse is raised toward the interrupt controller.

The first violation seen after the diagnostics were last released is captured. The block stores the faulting address and the identity of the bus master that issued the transfer. The master identity comes in on a sideband from the upstream bridge. Both diagnostic registers then freeze, so later violations still complete and still raise the interrupt but leave the registers untouched. Software reads the two registers through a separate small read-only APB port. Reading the address register releases the freeze.

Top module: `apb_addr_guard`

## Requirements
- R1: In the access phase of a transfer whose address lies in window k, `winSel` is one-hot with bit k set. `missReady` and `irq` stay low.
- R2: An access phase whose address lies in no window asserts `missReady` in that same phase, with `missSlvErr` low (an OKAY response).
- R3: A violating read returns zero on `missRdata`.
- R4: `irq` is high for exactly the access-phase cycle of every violation, whether or not the registers are frozen. It is low in setup phases and in idle cycles.
- R5: The first violation while unfrozen stores its address. The register reads back at register offset 0x0.
- R6: The same violation stores the master ID. It reads back at offset 0x4 in the low bits, with the upper bits zero.
- R7: While frozen, further violations change neither the address register nor the master-ID register. Reading offset 0x4 does not release the freeze.
- R8: A read of offset 0x0 releases the freeze on the clock edge that ends that access phase, so the next violation is captured.
- R9: After reset both registers read zero and the freeze is released.
- R10: Writes on the register port change nothing. Offsets other than 0x0 and 0x4 read zero.
- R11: A window spans base through base+size-1 inclusive. Base+size and base-1 are outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busPsel | input | 1 | Select of the monitored APB transfer |
| busPenable | input | 1 | Access-phase marker of the monitored transfer |
| busPaddr | input | ADDR_W | Address of the monitored transfer |
| busMid | input | MID_W | Master identity sideband from the bridge |
| winSel | output | NUM_WIN | Per-window select, gated by busPsel |
| missReady | output | 1 | Completion for a violating transfer |
| missSlvErr | output | 1 | Error flag for violating transfers, always OKAY |
| missRdata | output | DATA_W | Read data for violating transfers, zero |
| irq | output | 1 | Violation interrupt pulse |
| regPsel | input | 1 | Select of the diagnostic register port |
| regPenable | input | 1 | Access-phase marker of the register port |
| regPwrite | input | 1 | Write flag of the register port (writes ignored) |
| regPaddr | input | REG_AW | Register offset |
| regPready | output | 1 | Completion of register port transfers |
| regPrdata | output | DATA_W | Register read data |

## Verification
The decode outputs `winSel`, `missReady`, `missRdata` and `irq` are combinational. They are due in the same access-phase cycle in which `busPenable` rises, so the bench drives on the falling edge and samples one nanosecond later within that cycle. A capture or a release takes effect on the rising edge that ends the access phase. Register contents are therefore checked only through a register-port read issued after that edge, and register read data is likewise sampled inside its own access phase. `irq` is also sampled in the setup phase and in the idle cycle after each transfer, to confirm that the pulse lasts one cycle.

// File: rtl/apb_addr_guard_pkg.sv
package apb_addr_guard_pkg;

  // Register offsets on the diagnostic port
  localparam int unsigned OFF_ADDR = 0;
  localparam int unsigned OFF_MID  = 4;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_ADDR = 2'd1,
    RSEL_MID  = 2'd2
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    capture;
    regSel_e readSel;
  } strobe_t;

endpackage

// File: rtl/apb_addr_guard_ctrl.sv
module apb_addr_guard_ctrl
  import apb_addr_guard_pkg::*;
#(
  parameter int unsigned REG_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busPsel,
  input  logic              busPenable,
  input  logic              missHit,
  input  logic              regPsel,
  input  logic              regPenable,
  input  logic              regPwrite,
  input  logic [REG_AW-1:0] regPaddr,
  output strobe_t           strobe,
  output logic              lockedQ,
  output logic              irq,
  output logic              missReady,
  output logic              regPready
);

  localparam logic [REG_AW-1:0] ADDR_OFF = REG_AW'(OFF_ADDR);
  localparam logic [REG_AW-1:0] MID_OFF  = REG_AW'(OFF_MID);

  logic busAccess;
  logic regRead;
  logic addrRead;
  logic violation;
  logic lockClr;

  assign busAccess = busPsel && busPenable;
  assign violation = busAccess && missHit;
  assign regRead   = regPsel && !regPwrite;
  assign addrRead  = regRead && regPenable && (regPaddr == ADDR_OFF);
  assign lockClr   = addrRead;

  always_comb begin
    strobe.capture = violation && !lockedQ;
    if (regRead && regPaddr == ADDR_OFF) begin
      strobe.readSel = RSEL_ADDR;
    end else if (regRead && regPaddr == MID_OFF) begin
      strobe.readSel = RSEL_MID;
    end else begin
      strobe.readSel = RSEL_NONE;
    end
  end

  // Freeze flag: capture sets it, a read of the address register clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockedQ <= 1'b0;
    end else if (strobe.capture) begin
      lockedQ <= 1'b1;
    end else if (lockClr) begin
      lockedQ <= 1'b0;
    end
  end

  assign irq       = violation;
  assign missReady = violation;
  assign regPready = regPsel && regPenable;

  // R4: the interrupt appears only in an access phase
  a_r4_irq_access_only: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (busPsel && busPenable));

  // R4: APB needs a setup phase, so the pulse never lasts two cycles
  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R8: releasing read frees the lock on the next edge
  a_r8_release: assert property (@(posedge clk) disable iff (!rstN)
    (addrRead && !strobe.capture) |=> !lockedQ);

  // R5: an unfrozen violation always leads to the frozen state
  a_r5_lock_set: assert property (@(posedge clk) disable iff (!rstN)
    (violation && !lockedQ) |=> lockedQ);

endmodule

// File: rtl/apb_addr_guard_dp.sv
module apb_addr_guard_dp
  import apb_addr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned MID_W   = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_WIN = 4,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_BASE = '0,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_SIZE = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic               lockedQ,
  input  logic               busPsel,
  input  logic [ADDR_W-1:0]  busPaddr,
  input  logic [MID_W-1:0]   busMid,
  output logic [NUM_WIN-1:0] winSel,
  output logic               missHit,
  output logic [DATA_W-1:0]  missRdata,
  output logic [DATA_W-1:0]  regPrdata
);

  logic [NUM_WIN-1:0] winHit;
  logic [ADDR_W-1:0]  addrQ;
  logic [MID_W-1:0]   midQ;

  // One range comparator per window
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic [ADDR_W-1:0] offs;
    assign offs      = busPaddr - WIN_BASE[g];
    assign winHit[g] = (busPaddr >= WIN_BASE[g]) && (offs < WIN_SIZE[g]);
    assign winSel[g] = busPsel && winHit[g];
  end

  assign missHit   = busPsel && (winHit == '0);
  assign missRdata = '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      midQ  <= '0;
    end else if (strobe.capture) begin
      addrQ <= busPaddr;
      midQ  <= busMid;
    end
  end

  always_comb begin
    unique case (strobe.readSel)
      RSEL_ADDR: regPrdata = DATA_W'(addrQ);
      RSEL_MID:  regPrdata = DATA_W'(midQ);
      default:   regPrdata = '0;
    endcase
  end

  // R5, R6: capture stores the transfer's address and master
  a_r5_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (addrQ == $past(busPaddr)) && (midQ == $past(busMid)));

  // R7: frozen registers hold
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rstN)
    lockedQ |=> ($stable(addrQ) && $stable(midQ)));

  // R1: windows do not overlap
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winSel));

endmodule

// File: rtl/apb_addr_guard.sv
module apb_addr_guard
  import apb_addr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned MID_W   = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned REG_AW  = 4,
  parameter int unsigned NUM_WIN = 4,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_BASE =
    {32'h4001_0000, 32'h4000_4000, 32'h4000_2000, 32'h4000_0000},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_SIZE =
    {32'h0001_0000, 32'h0000_0400, 32'h0000_1000, 32'h0000_1000}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busPsel,
  input  logic               busPenable,
  input  logic [ADDR_W-1:0]  busPaddr,
  input  logic [MID_W-1:0]   busMid,
  output logic [NUM_WIN-1:0] winSel,
  output logic               missReady,
  output logic               missSlvErr,
  output logic [DATA_W-1:0]  missRdata,
  output logic               irq,
  input  logic               regPsel,
  input  logic               regPenable,
  input  logic               regPwrite,
  input  logic [REG_AW-1:0]  regPaddr,
  output logic               regPready,
  output logic [DATA_W-1:0]  regPrdata
);

  strobe_t strobe;
  logic    missHit;
  logic    lockedQ;

  apb_addr_guard_ctrl #(.REG_AW(REG_AW)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busPsel    (busPsel),
    .busPenable (busPenable),
    .missHit    (missHit),
    .regPsel    (regPsel),
    .regPenable (regPenable),
    .regPwrite  (regPwrite),
    .regPaddr   (regPaddr),
    .strobe     (strobe),
    .lockedQ    (lockedQ),
    .irq        (irq),
    .missReady  (missReady),
    .regPready  (regPready)
  );

  apb_addr_guard_dp #(
    .ADDR_W   (ADDR_W),
    .MID_W    (MID_W),
    .DATA_W   (DATA_W),
    .NUM_WIN  (NUM_WIN),
    .WIN_BASE (WIN_BASE),
    .WIN_SIZE (WIN_SIZE)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lockedQ   (lockedQ),
    .busPsel   (busPsel),
    .busPaddr  (busPaddr),
    .busMid    (busMid),
    .winSel    (winSel),
    .missHit   (missHit),
    .missRdata (missRdata),
    .regPrdata (regPrdata)
  );

  assign missSlvErr = 1'b0;

  // R2: an unmatched access phase is always completed
  a_r2_complete: assert property (@(posedge clk) disable iff (!rstN)
    (busPsel && busPenable && (winSel == '0)) |-> missReady);

  // R1: a matched transfer never raises the interrupt
  a_r1_no_irq_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    (winSel != '0) |-> !irq);

endmodule

// File: tb/test_apb_addr_guard.sv
module test_apb_addr_guard;

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [3:0]  mid;
    logic [3:0]  expSel;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h4000_0000, 1'b0, 4'h1, 4'b0001},  // R11 base of window 0
    '{32'h4000_0FFF, 1'b1, 4'h2, 4'b0001},  // R11 last byte of window 0
    '{32'h4000_1000, 1'b0, 4'h3, 4'b0000},  // R11 one past window 0 -> first capture
    '{32'h4000_2010, 1'b1, 4'h4, 4'b0010},
    '{32'h4000_1FFF, 1'b1, 4'h5, 4'b0000},  // R11 base-1 of window 1
    '{32'h4000_43FF, 1'b0, 4'h6, 4'b0100},
    '{32'h4000_4400, 1'b0, 4'h7, 4'b0000},
    '{32'h4001_FFFF, 1'b1, 4'h8, 4'b1000},
    '{32'h4002_0000, 1'b0, 4'h9, 4'b0000},
    '{32'h0000_0000, 1'b1, 4'hA, 4'b0000},
    '{32'h4001_0000, 1'b0, 4'hB, 4'b1000},
    '{32'hFFFF_FFFC, 1'b0, 4'hC, 4'b0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busPsel = 1'b0, busPenable = 1'b0;
  logic [31:0] busPaddr = '0;
  logic [3:0]  busMid = '0;
  logic [3:0]  winSel;
  logic        missReady, missSlvErr, irq;
  logic [31:0] missRdata;
  logic        regPsel = 1'b0, regPenable = 1'b0, regPwrite = 1'b0;
  logic [3:0]  regPaddr = '0;
  logic        regPready;
  logic [31:0] regPrdata;

  int nChk = 0;
  int nErr = 0;
  logic        expLock = 1'b0;
  logic [31:0] expAddr = '0;
  logic [3:0]  expMid = '0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  apb_addr_guard i_apb_addr_guard (
    .clk(clk), .rstN(rstN),
    .busPsel(busPsel), .busPenable(busPenable), .busPaddr(busPaddr), .busMid(busMid),
    .winSel(winSel), .missReady(missReady), .missSlvErr(missSlvErr),
    .missRdata(missRdata), .irq(irq),
    .regPsel(regPsel), .regPenable(regPenable), .regPwrite(regPwrite),
    .regPaddr(regPaddr), .regPready(regPready), .regPrdata(regPrdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busXfer(input logic [31:0] addr, input logic wr, input logic [3:0] mid,
                         input logic [3:0] expSel);
    logic miss;
    miss = (expSel == 4'b0000);
    @(negedge clk);
    busPsel = 1'b1; busPenable = 1'b0; busPaddr = addr; busMid = mid;
    #1 chk("R4 irq low in setup", 32'(irq), 32'd0);
    @(negedge clk);
    busPenable = 1'b1;
    #1;
    chk("R1/R11 winSel", 32'(winSel), 32'(expSel));
    chk("R2 missReady", 32'(missReady), 32'(miss));
    chk("R4 irq in access", 32'(irq), 32'(miss));
    if (miss) chk("R2 OKAY response", 32'(missSlvErr), 32'd0);
    if (miss && !wr) chk("R3 zero read data", missRdata, 32'd0);
    @(negedge clk);
    busPsel = 1'b0; busPenable = 1'b0;
    #1 chk("R4 irq low after access", 32'(irq), 32'd0);
    if (miss && !expLock) begin
      expLock = 1'b1; expAddr = addr; expMid = mid;
    end
  endtask

  task automatic regXfer(input logic [3:0] off, input logic wr, output logic [31:0] data);
    @(negedge clk);
    regPsel = 1'b1; regPenable = 1'b0; regPwrite = wr; regPaddr = off;
    @(negedge clk);
    regPenable = 1'b1;
    #1 data = regPrdata;
    chk("R10 regPready", 32'(regPready), 32'd1);
    @(negedge clk);
    regPsel = 1'b0; regPenable = 1'b0; regPwrite = 1'b0;
    if (off == 4'h0 && !wr) expLock = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R9 irq idle after reset", 32'(irq), 32'd0);
    chk("R9 missReady idle", 32'(missReady), 32'd0);
    regXfer(4'h0, 1'b0, rd); chk("R9 address reg zero", rd, 32'd0);
    regXfer(4'h4, 1'b0, rd); chk("R9 master reg zero", rd, 32'd0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      busXfer(VECS[i].addr, VECS[i].wr, VECS[i].mid, VECS[i].expSel);
    end

    // R7: only the first violation is held; master read keeps the freeze
    regXfer(4'h4, 1'b0, rd); chk("R6/R7 master reg", rd, 32'(expMid));
    regXfer(4'h4, 1'b0, rd); chk("R6/R7 master reg repeat", rd, 32'h3);

    // R10: write attempt and unused offset
    regXfer(4'h0, 1'b1, rd);
    regXfer(4'h8, 1'b0, rd); chk("R10 unused offset zero", rd, 32'd0);
    busXfer(32'h5000_0000, 1'b0, 4'h7, 4'b0000);
    regXfer(4'h4, 1'b0, rd); chk("R7/R10 master reg held", rd, 32'h3);
    regXfer(4'h0, 1'b0, rd); chk("R5/R7 address reg held", rd, 32'h4000_1000);

    // R8: released -> next violation captured
    busXfer(32'h3000_0000, 1'b1, 4'hE, 4'b0000);
    regXfer(4'h4, 1'b0, rd); chk("R8 master after release", rd, 32'hE);
    regXfer(4'h0, 1'b0, rd); chk("R8 address after release", rd, 32'h3000_0000);
    busXfer(32'h6000_0000, 1'b0, 4'h1, 4'b0000);
    regXfer(4'h0, 1'b0, rd); chk("R8 second release capture", rd, 32'h6000_0000);

    // R9: reset while frozen
    busXfer(32'h6100_0000, 1'b0, 4'h5, 4'b0000);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    expLock = 1'b0;
    regXfer(4'h4, 1'b0, rd); chk("R9 master cleared by reset", rd, 32'd0);
    busXfer(32'h7000_0000, 1'b0, 4'h2, 4'b0000);
    regXfer(4'h4, 1'b0, rd); chk("R9 unlocked after reset (mid)", rd, 32'h2);
    regXfer(4'h0, 1'b0, rd); chk("R9 unlocked after reset (addr)", rd, 32'h7000_0000);

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

endmodule